// File: doc/BRIEF.md
# Segmented Address Translation Fault Unit

This unit sits between the address generation stage and the memory system of a processor. For each instruction fetch, load or store it takes the 32-bit virtual address, the access size, the processor status word and the entry returned by an external translation lookaside buffer (TLB) search. It produces the physical address, an uncacheable flag and a one-hot fault vector, one cycle after the request.

Two fixed windows of the address space bypass the TLB. The cached kernel window (top three address bits `100`) is reachable only from kernel mode. The uncached kernel window (`101`) is open to every mode. All other addresses are mapped. For a mapped address the unit forms the page number that the TLB is searched with. It picks the even or odd frame of the hit entry with the address bit at the entry's page-shift position, and splices frame and offset together.

When an access fails, the unit reports the class of the fault. It also reports the values that the exception logic must capture: the faulting address, the address space identifier, the page-pair number and the low page-number bits. The TLB array and the exception vectoring are outside this block.

Top module: `xlat_fault_unit`

## Requirements
- R1: An access is misaligned when `(req_size-1) & req_vaddr` is nonzero. A misaligned access in the cached kernel window or in a mapped region raises an address error. That error is fault bit 1 for a store (`req_kind`=2'b10) and fault bit 0 for a fetch (2'b00) or a load (2'b01). Misalignment takes priority over every TLB outcome.
- R2: An address whose bits [31:29] are `100` is not translated. Its physical address is `req_vaddr[28:0]`. It raises the address error of R1 when the processor is not in kernel mode.
- R3: Kernel mode holds when `status & 32'h1000_0006` is nonzero, or when `status[4:3]` is `00`. The value `01` (supervisor) and the value `10` (user) are not kernel mode when the other bits are clear.
- R4: An address whose bits [31:29] are `101` maps to `req_vaddr[28:0]`. It never faults, whatever the mode or the alignment.
- R5: The search page number `vpn` is `req_vaddr[31:11]`. When `small_pages` is 0, its two lowest bits are forced to 0.
- R6: On a mapped hit, `req_vaddr[tlb_shift]` selects the frame: 0 picks the even frame, valid bit and dirty bit, and 1 picks the odd ones. The physical address is `((pfn >> (tlb_shift-12)) << tlb_shift) | (req_vaddr mod 2^tlb_shift)`, with `tlb_shift` in 12..28.
- R7: A mapped access with `tlb_hit`=0 raises a refill fault. That is bit 2 for a fetch and bit 4 for a load or a store.
- R8: A hit whose selected valid bit is 0 raises an invalid fault. That is bit 3 for a fetch and bit 5 for a load or a store.
- R9: A store that hits a valid frame whose dirty bit is 0 raises the modified fault, bit 6. Fetches and loads ignore the dirty bit.
- R10: Every fault sets `rsp_bad_vaddr` to the request address. A refill, invalid or modified fault also outputs `rsp_asid` = `req_asid`, `rsp_vpn2` = `vpn>>2` (which is also the Context page-pair value) and `rsp_vpn2x` = `vpn[1:0]`. Other outcomes drive these three outputs to 0, and `rsp_bad_vaddr` is 0 when no fault is raised.
- R11: With no fault, `rsp_uncached` is 1 exactly when `req_vaddr[31]` and `req_vaddr[29]` are both 1.
- R12: Every request is answered on the following cycle with `rsp_valid`. `rsp_fault` is one-hot or zero. When `rsp_fault` is nonzero, `rsp_paddr` and `rsp_uncached` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_asid | input | ASID_W | Address space identifier of the access |
| status | input | 32 | Processor status word |
| small_pages | input | 1 | Small-page mode for page-number formation |
| tlb_hit | input | 1 | TLB search found an entry |
| tlb_shift | input | 5 | Page-shift position of the hit entry (12..28) |
| tlb_pfn0 | input | PFN_W | Even frame number |
| tlb_pfn1 | input | PFN_W | Odd frame number |
| tlb_v0 | input | 1 | Even frame valid |
| tlb_v1 | input | 1 | Odd frame valid |
| tlb_d0 | input | 1 | Even frame writable |
| tlb_d1 | input | 1 | Odd frame writable |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | PFN_W+12 | Physical address |
| rsp_uncached | output | 1 | Access bypasses the caches |
| rsp_fault | output | 7 | One-hot fault class |
| rsp_bad_vaddr | output | 32 | Faulting address |
| rsp_asid | output | ASID_W | Captured identifier |
| rsp_vpn2 | output | 19 | Captured page-pair number |
| rsp_vpn2x | output | 2 | Captured low page-number bits |

## Verification
The bench aims at the orderings that a careless design reverses. A misaligned store to a missing page must report an address error and not a refill. A design that checks the TLB first would report the refill instead. A misaligned or user-mode access to the uncached kernel window must pass, so a design that shares the cached window's checks would wrongly fault there. Status words with only the error or exception-level bits set must count as kernel, or a narrow mode decode rejects legal accesses. Random mapped traffic over several page sizes and both frame halves checks the select bit and the offset splice. A store to a clean page must fault while a load of it must not, and the low page-number bits must vanish without small-page mode, or the captured fields are wrong.

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit #(
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_vaddr,
  input  logic [3:0]        req_size,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [31:0]       status,
  input  logic              small_pages,
  input  logic              tlb_hit,
  input  logic [4:0]        tlb_shift,
  input  logic [PFN_W-1:0]  tlb_pfn0,
  input  logic [PFN_W-1:0]  tlb_pfn1,
  input  logic              tlb_v0,
  input  logic              tlb_v1,
  input  logic              tlb_d0,
  input  logic              tlb_d1,
  output logic              rsp_valid,
  output logic [PFN_W+11:0] rsp_paddr,
  output logic              rsp_uncached,
  output logic [6:0]        rsp_fault,
  output logic [31:0]       rsp_bad_vaddr,
  output logic [ASID_W-1:0] rsp_asid,
  output logic [18:0]       rsp_vpn2,
  output logic [1:0]        rsp_vpn2x
);
  localparam int PA_W = PFN_W + 12;

  logic            is_store, is_fetch, kernel, misal, win_c, win_u;
  logic            odd, sel_v, sel_d, tlb_fault;
  logic [20:0]     vpn;
  logic [PA_W-1:0] mask, frame, pa;
  logic [6:0]      f;

  assign is_store = (req_kind == 2'b10);
  assign is_fetch = (req_kind == 2'b00);
  assign kernel   = (|(status & 32'h1000_0006)) || (status[4:3] == 2'b00);
  assign misal    = |((req_size - 4'd1) & req_vaddr[3:0]);
  assign win_c    = (req_vaddr[31:29] == 3'b100);
  assign win_u    = (req_vaddr[31:29] == 3'b101);
  assign vpn      = {req_vaddr[31:13], small_pages ? req_vaddr[12:11] : 2'b00};
  assign odd      = req_vaddr[tlb_shift];
  assign sel_v    = odd ? tlb_v1 : tlb_v0;
  assign sel_d    = odd ? tlb_d1 : tlb_d0;
  assign mask     = (PA_W'(1) << tlb_shift) - PA_W'(1);
  assign frame    = {(odd ? tlb_pfn1 : tlb_pfn0), 12'h000};

  always_comb begin
    f         = '0;
    pa        = '0;
    tlb_fault = 1'b0;
    if (win_u) begin
      pa = PA_W'(req_vaddr[28:0]);
    end else if (win_c) begin
      if (misal || !kernel) f[is_store ? 1 : 0] = 1'b1;
      else                  pa = PA_W'(req_vaddr[28:0]);
    end else if (misal) begin
      f[is_store ? 1 : 0] = 1'b1;
    end else if (!tlb_hit) begin
      f[is_fetch ? 2 : 4] = 1'b1;
      tlb_fault = 1'b1;
    end else if (!sel_v) begin
      f[is_fetch ? 3 : 5] = 1'b1;
      tlb_fault = 1'b1;
    end else if (is_store && !sel_d) begin
      f[6] = 1'b1;
      tlb_fault = 1'b1;
    end else begin
      pa = (frame & ~mask) | (PA_W'(req_vaddr) & mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_uncached  <= 1'b0;
      rsp_fault     <= '0;
      rsp_bad_vaddr <= '0;
      rsp_asid      <= '0;
      rsp_vpn2      <= '0;
      rsp_vpn2x     <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? f : 7'd0;
      if (req_valid) begin
        rsp_paddr     <= pa;
        rsp_uncached  <= (f == 7'd0) && req_vaddr[31] && req_vaddr[29];
        rsp_bad_vaddr <= (f != 7'd0) ? req_vaddr : 32'd0;
        rsp_asid      <= tlb_fault ? req_asid : '0;
        rsp_vpn2      <= tlb_fault ? vpn[20:2] : 19'd0;
        rsp_vpn2x     <= tlb_fault ? vpn[1:0] : 2'd0;
      end
    end
  end

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_fault_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_fault));
  p_fault_zero_pa_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 7'd0) |-> (rsp_paddr == '0 && !rsp_uncached));
  p_uncached_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[31:29] == 3'b101) |=>
      (rsp_fault == 7'd0 && rsp_uncached && rsp_paddr == PA_W'($past(req_vaddr[28:0]))));
  p_modified_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault[6] |-> ($past(req_kind) == 2'b10));
endmodule

// File: tb/sim_xlat_fault_unit.sv
module sim_xlat_fault_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;

  typedef struct {
    logic [31:0] pa;
    logic        unc;
    logic [6:0]  flt;
    logic [31:0] bad;
    logic [7:0]  asid;
    logic [18:0] vpn2;
    logic [1:0]  vpn2x;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [31:0] req_vaddr = '0, status = '0;
  logic [3:0] req_size = 4'd4;
  logic [7:0] req_asid = '0;
  logic small_pages = 1'b0, tlb_hit = 1'b0;
  logic [4:0] tlb_shift = 5'd12;
  logic [19:0] tlb_pfn0 = '0, tlb_pfn1 = '0;
  logic tlb_v0 = 1'b0, tlb_v1 = 1'b0, tlb_d0 = 1'b0, tlb_d1 = 1'b0;
  logic rsp_valid, rsp_uncached;
  logic [31:0] rsp_paddr, rsp_bad_vaddr;
  logic [6:0] rsp_fault;
  logic [7:0] rsp_asid;
  logic [18:0] rsp_vpn2;
  logic [1:0] rsp_vpn2x;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_fault_unit #(.ASID_W(ASID_W), .PFN_W(PFN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_vaddr(req_vaddr), .req_size(req_size), .req_asid(req_asid),
    .status(status), .small_pages(small_pages), .tlb_hit(tlb_hit),
    .tlb_shift(tlb_shift), .tlb_pfn0(tlb_pfn0), .tlb_pfn1(tlb_pfn1),
    .tlb_v0(tlb_v0), .tlb_v1(tlb_v1), .tlb_d0(tlb_d0), .tlb_d1(tlb_d1),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault), .rsp_bad_vaddr(rsp_bad_vaddr), .rsp_asid(rsp_asid),
    .rsp_vpn2(rsp_vpn2), .rsp_vpn2x(rsp_vpn2x));

  function automatic exp_t model(string tag);
    exp_t e;
    bit kern, mis, store, odd, v, d, tf;
    logic [20:0] pn;
    logic [19:0] pfn;
    e.tag = tag; e.pa = 0; e.flt = 0; tf = 0;
    store = (req_kind == 2'b10);
    kern = (status[28] | status[2] | status[1]) || (status[4:3] == 2'b00);
    mis = ((32'(req_size) - 1) & req_vaddr) != 0;
    pn = req_vaddr >> 11;
    if (!small_pages) pn = pn & ~21'h3;
    case (req_vaddr[31:29])
      3'b101: e.pa = req_vaddr % 32'h2000_0000;
      3'b100: if (mis || !kern) e.flt = store ? 7'h02 : 7'h01;
              else e.pa = req_vaddr % 32'h2000_0000;
      default: begin
        odd = (req_vaddr >> tlb_shift) & 1;
        v = odd ? tlb_v1 : tlb_v0;
        d = odd ? tlb_d1 : tlb_d0;
        pfn = odd ? tlb_pfn1 : tlb_pfn0;
        if (mis) e.flt = store ? 7'h02 : 7'h01;
        else if (!tlb_hit) begin e.flt = (req_kind == 0) ? 7'h04 : 7'h10; tf = 1; end
        else if (!v) begin e.flt = (req_kind == 0) ? 7'h08 : 7'h20; tf = 1; end
        else if (store && !d) begin e.flt = 7'h40; tf = 1; end
        else e.pa = ((32'(pfn) >> (tlb_shift - 12)) << tlb_shift)
                    | (req_vaddr % (32'd1 << tlb_shift));
      end
    endcase
    e.unc = (e.flt == 0) && ((req_vaddr & 32'hA000_0000) == 32'hA000_0000);
    e.bad = (e.flt != 0) ? req_vaddr : 0;
    e.asid = tf ? req_asid : 0;
    e.vpn2 = tf ? 19'(pn >> 2) : 0;
    e.vpn2x = tf ? pn[1:0] : 0;
    return e;
  endfunction

  task automatic send(string tag);
    q.push_back(model(tag));
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic setreq(logic [1:0] k, logic [31:0] va, logic [3:0] sz, logic [31:0] st);
    req_kind = k; req_vaddr = va; req_size = sz; status = st;
  endtask

  task automatic setent(bit hit, int sh, logic [19:0] p0, logic [19:0] p1,
                        bit v0, bit v1, bit d0, bit d1);
    tlb_hit = hit; tlb_shift = 5'(sh); tlb_pfn0 = p0; tlb_pfn1 = p1;
    tlb_v0 = v0; tlb_v1 = v1; tlb_d0 = d0; tlb_d1 = d1;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected response: actual valid=1 expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_paddr !== e.pa || rsp_uncached !== e.unc || rsp_fault !== e.flt ||
            rsp_bad_vaddr !== e.bad || rsp_asid !== e.asid || rsp_vpn2 !== e.vpn2 ||
            rsp_vpn2x !== e.vpn2x) begin
          fails++;
          $display("FAIL %s actual pa=%h unc=%b flt=%h bad=%h asid=%h vpn2=%h x=%h expected pa=%h unc=%b flt=%h bad=%h asid=%h vpn2=%h x=%h",
            e.tag, rsp_paddr, rsp_uncached, rsp_fault, rsp_bad_vaddr, rsp_asid, rsp_vpn2,
            rsp_vpn2x, e.pa, e.unc, e.flt, e.bad, e.asid, e.vpn2, e.vpn2x);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 7'd0) begin
      fails++;
      $display("FAIL R12 reset: actual valid=%b flt=%h expected 0 0", rsp_valid, rsp_fault);
    end
    rst_n = 1'b1;
    @(negedge clk);
    req_asid = 8'h5A;

    // R2 R3: cached kernel window
    setent(1, 12, 20'h11111, 20'h22222, 1, 1, 1, 1);
    setreq(2'b01, 32'h8012_3454, 4'd4, 32'h0000_0000); send("R2 kernel load");
    setreq(2'b01, 32'h8012_3454, 4'd4, 32'h0000_0010); send("R3 user faults");
    setreq(2'b10, 32'h8012_3454, 4'd4, 32'h0000_0008); send("R3 supervisor store faults");
    setreq(2'b00, 32'h8000_0100, 4'd4, 32'h0000_0012); send("R3 exl kernel");
    setreq(2'b01, 32'h8000_0100, 4'd4, 32'h0000_0014); send("R3 erl kernel");
    setreq(2'b01, 32'h8000_0100, 4'd4, 32'h1000_0010); send("R3 bit28 kernel");
    setreq(2'b10, 32'h8000_0102, 4'd4, 32'h0000_0000); send("R1 kseg misaligned store");
    // R4 uncached window
    setreq(2'b01, 32'hA000_0003, 4'd4, 32'h0000_0010); send("R4 user misaligned passes");
    setreq(2'b10, 32'hBFFF_FFF0, 4'd8, 32'h0000_0008); send("R4 supervisor store");
    // R1 priority over TLB outcome
    setent(0, 12, 0, 0, 0, 0, 0, 0);
    setreq(2'b10, 32'h0040_1006, 4'd4, 32'h10); send("R1 misaligned beats refill");
    setreq(2'b00, 32'h0040_1001, 4'd2, 32'h10); send("R1 fetch misaligned");
    setreq(2'b01, 32'h0040_1004, 4'd8, 32'h10); send("R1 load size8");
    // R7 refill + R10 + R5
    small_pages = 1'b0;
    setreq(2'b00, 32'h0040_1800, 4'd4, 32'h10); send("R7 fetch refill R5 large");
    setreq(2'b01, 32'h7FFF_F800, 4'd4, 32'h10); send("R7 load refill R10");
    small_pages = 1'b1;
    setreq(2'b10, 32'h0040_1800, 4'd4, 32'h10); send("R5 small refill vpn2x");
    small_pages = 1'b0;
    // R8 invalid
    setent(1, 12, 20'h11111, 20'h22222, 1, 0, 1, 1);
    setreq(2'b00, 32'h0040_1000, 4'd4, 32'h10); send("R8 fetch odd invalid");
    setreq(2'b01, 32'h0040_0000, 4'd4, 32'h10); send("R6 even valid load");
    setreq(2'b01, 32'h0040_1000, 4'd4, 32'h10); send("R8 load odd invalid");
    // R9 modified
    setent(1, 14, 20'h00AB4, 20'h00CD8, 1, 1, 0, 1);
    setreq(2'b10, 32'h1234_0123, 4'd1, 32'h10); send("R9 store clean even");
    setreq(2'b01, 32'h1234_0120, 4'd4, 32'h10); send("R9 load clean ok");
    setreq(2'b00, 32'h1234_0120, 4'd4, 32'h10); send("R9 fetch clean ok");
    setreq(2'b10, 32'h1234_4120, 4'd4, 32'h10); send("R6 store dirty odd");
    // R11 mapped top region uncached
    setent(1, 12, 20'hFFFFF, 20'h00001, 1, 1, 1, 1);
    setreq(2'b01, 32'hE000_0ABC, 4'd4, 32'h10); send("R11 mapped 0xE uncached");
    setreq(2'b01, 32'hC000_1ABC, 4'd4, 32'h10); send("R11 mapped 0xC cached");
    // R6 random mapped traffic
    for (int i = 0; i < 300; i++) begin
      logic [31:0] va;
      int sh;
      va = $urandom;
      if (va[31:30] == 2'b10) va[31] = 1'b0;
      sh = $urandom_range(12, 24);
      va = va & ~((32'd1 << sh) - 1) | (va & ((32'd1 << sh) - 1) & 32'hFFFF_FFFC);
      setent($urandom_range(0, 7) != 0, sh, 20'($urandom), 20'($urandom),
             $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
             $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
      small_pages = $urandom_range(0, 1);
      req_asid = 8'($urandom);
      setreq(2'($urandom_range(0, 2)), va, 4'd4, 32'h10);
      send("R6 random mapped");
    end
    repeat (3) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R12 missing responses: actual %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule